// File: doc/BRIEF.md
# Integer ALU with Status-Flag Generation

This block performs the integer arithmetic, shift and rotate steps of a general-purpose core. It also produces the six status flags that those steps define. Each operation is presented for one cycle with a valid strobe, together with its operands, an operand-size select (half or full datapath width), a shift count and the current flag word. One clock later the block presents three outputs: the result, the next flag word, and a destination write-enable.

Flag updates follow per-operation rules rather than a single shared rule:

- Increment and decrement preserve the carry flag.
- Shift and rotate counts are masked to the operand size.
- A masked count of zero is a complete no-op.
- Rotates touch only carry and overflow.
- The single-width compare-and-exchange sets all six flags as a subtraction would.
- The double-width compare-and-exchange affects only the zero flag.

Exchanging the operands, decoding instructions and accessing memory are left to the surrounding core.

With the default 64-bit datapath, H = 32 is the narrow operand size and W = 64 is the wide one.

Top module: `alu_flag_unit`

## Requirements
- R1: The opcode encodings are ADD=0, SUB=1, CMP=2, INC=3, DEC=4, SHL=5, SHR=6, SAR=7, ROL=8, ROR=9, single compare-exchange=10 and double compare-exchange=11. The flag word packs CF at bit 0, PF at bit 1, AF at bit 2, ZF at bit 3, SF at bit 4 and OF at bit 5. When size_i is 1 the operands are W bits wide; when it is 0 they are H bits wide, and the H-bit results are zero-extended. Every output registers one cycle after a cycle in which start_i is high, and done_o pulses high for exactly that cycle. While start_i is low, wr_o stays low and res_o holds its value.
- R2: ADD returns (a+b) modulo the operand size. CF is the carry out of the top bit of that size, OF signals signed overflow, and wr_o is 1.
- R3: SUB and CMP return a-b. CF is the borrow, which is set when a is unsigned-less than b, and OF signals signed overflow. SUB sets wr_o to 1 and CMP sets it to 0.
- R4: INC and DEC add or subtract one and update OF, SF, ZF, AF and PF. CF stays exactly as it was in flags_i.
- R5: Wherever the arithmetic and logical flags are written, they are defined as follows:
  - ZF is set when the result is zero.
  - SF is the top bit of the result at the operand size.
  - PF is set when the result's low byte has an even number of 1 bits.
  - AF is the carry or borrow out of bit 3.
- R6: For the shift and rotate opcodes the count is masked to 5 bits when size_i is 0 and to 6 bits when size_i is 1.
- R7: For a shift or rotate with a masked count of zero, flags_o equals flags_i, res_o equals a_i and wr_o is 0.
- R8: For SHL, SHR and SAR with a nonzero masked count:
  - CF is the last bit shifted out, and AF is unchanged.
  - With a masked count of 1, OF is the result's top bit XOR CF for SHL, the original top bit for SHR, and 0 for SAR.
  - With a masked count above 1, OF is unchanged.
- R9: For ROL and ROR with a nonzero masked count, only CF and OF may change:
  - For ROL, CF is bit 0 of the result.
  - For ROR, CF is the top bit of the result.
  - With a masked count of 1, OF is the top bit XOR bit 0 for ROL, and the XOR of the two top bits for ROR.
- R10: The single compare-exchange writes all six flags exactly as a-b would, with a as the accumulator and b as the destination. Its wr_o is 0.
- R11: The double compare-exchange sets ZF exactly when all W bits of a_i equal those of b_i. It leaves the other five flags unchanged, returns a_i and sets wr_o to 0.
- R12: Opcodes 12 to 15 return a_i and pass flags_i through unchanged, with wr_o at 0.
- R13: While rst_ni is low at a clock edge, done_o, wr_o, res_o and flags_o are cleared to zero at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode |
| size_i | input | 1 | Operand size: 0 selects half width, 1 selects full width |
| a_i | input | DATA_W | First operand, the destination or accumulator |
| b_i | input | DATA_W | Second operand |
| cnt_i | input | CNT_W | Raw shift or rotate count |
| flags_i | input | 6 | Current flag word |
| done_o | output | 1 | Output-valid pulse |
| res_o | output | DATA_W | Result |
| flags_o | output | 6 | Next flag word |
| wr_o | output | 1 | Destination write-enable |

## Verification
The bound assertions assume three things about the inputs. Every input is driven to known values and changes only away from the clock edge. start_i stays low while reset is asserted. flags_i carries the flag word that an operation is supposed to leave untouched, because several properties compare flags_o one cycle later against it.

The stimulus drives all inputs at the falling edge, so each input is stable at the sampling edge, and it holds start_i low throughout reset. The random stimulus covers several kinds of input, so the count-zero, count-one, wide-equality and narrow-masking paths are all reached:

- random flag words and random operands;
- counts biased towards 0, 1, the narrow-mask boundary and the full mask;
- frequent equal operand pairs;
- upper operand bits that are deliberately non-zero in narrow mode.

// File: rtl/alu_flag_pkg.sv
// Shared definitions for the ALU flag unit: opcode encoding, flag word
// layout and helpers that classify opcodes.
package alu_flag_pkg;

    localparam int FLAG_W = 6;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_INC = 4'd3,
        OP_DEC = 4'd4,
        OP_SHL = 4'd5,
        OP_SHR = 4'd6,
        OP_SAR = 4'd7,
        OP_ROL = 4'd8,
        OP_ROR = 4'd9,
        OP_CXS = 4'd10,
        OP_CXD = 4'd11
    } alu_op_e;

    // Packed MSB first: of is bit 5, cf is bit 0.
    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flags_t;

    // True for the shift and rotate group.
    function automatic logic op_is_shift(input logic [3:0] op);
        return (op >= 4'd5) && (op <= 4'd9);
    endfunction

    // True for the add/subtract/compare group.
    function automatic logic op_is_arith(input logic [3:0] op);
        return (op <= 4'd4) || (op == 4'd10) || (op == 4'd11);
    endfunction

endpackage

// File: rtl/afu_szp.sv
// Zero, sign and parity flags of a result.
// Assumes: res is already masked to the operand size (upper half zero when
// wide is 0). DATA_W is even and at least 16.
module afu_szp #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] res,
    input  logic              wide,
    output logic              zf,
    output logic              sf,
    output logic              pf
);
    localparam int HALF_W = DATA_W / 2;

    // Reduce the result to the three size-dependent flags.
    always_comb begin : szp_reduce
        zf = (res == '0);
        sf = wide ? res[DATA_W-1] : res[HALF_W-1];
        pf = ~^res[7:0];
    end
endmodule

// File: rtl/afu_arith.sv
// Add / subtract datapath with flag generation for ADD, SUB, CMP, INC, DEC
// and both compare-exchange forms.
// Assumes: op is an arithmetic-group opcode (other values give a don't-care
// output that the top does not select). Operand bits above the half width
// are ignored when wide is 0.
module afu_arith
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  alu_op_e           op,
    input  logic              wide,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  flags_t            fin,
    output logic [DATA_W-1:0] res,
    output flags_t            fout,
    output logic              we
);
    localparam int                HALF_W    = DATA_W / 2;
    localparam logic [DATA_W-1:0] HALF_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] a_m;
    logic [DATA_W-1:0] b_m;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] r;
    logic [DATA_W:0]   sum;
    logic              subtract;
    logic              step;
    logic              carry;
    logic              msb_a;
    logic              msb_b;
    logic              ov;
    logic              aux;
    logic              zf_r;
    logic              sf_r;
    logic              pf_r;

    // Mask operands to the operand size and pick the second operand.
    always_comb begin : operand_prep
        mask     = wide ? '1 : HALF_MASK;
        a_m      = a & mask;
        b_m      = b & mask;
        step     = (op == OP_INC) || (op == OP_DEC);
        opb      = step ? DATA_W'(1) : b_m;
        subtract = (op == OP_SUB) || (op == OP_CMP) ||
                   (op == OP_DEC) || (op == OP_CXS);
    end

    // One adder/subtractor, one bit wider than the datapath to keep the carry.
    always_comb begin : adder
        sum   = subtract ? ({1'b0, a_m} - {1'b0, opb})
                         : ({1'b0, a_m} + {1'b0, opb});
        r     = sum[DATA_W-1:0] & mask;
        carry = wide ? sum[DATA_W] : sum[HALF_W];
        msb_a = wide ? a_m[DATA_W-1] : a_m[HALF_W-1];
        msb_b = wide ? opb[DATA_W-1] : opb[HALF_W-1];
        aux   = a_m[4] ^ opb[4] ^ r[4];
    end

    afu_szp #(.DATA_W(DATA_W)) u_szp (
        .res  (r),
        .wide (wide),
        .zf   (zf_r),
        .sf   (sf_r),
        .pf   (pf_r)
    );

    // Signed overflow from operand and result signs.
    always_comb begin : overflow
        if (subtract) ov = (msb_a != msb_b) && (sf_r != msb_a);
        else          ov = (msb_a == msb_b) && (sf_r != msb_a);
    end

    // Apply the per-opcode flag update rules.
    always_comb begin : flag_rules
        fout = fin;
        res  = r;
        we   = 1'b0;
        case (op)
            OP_ADD, OP_SUB, OP_CMP, OP_CXS: begin
                fout.cf = carry;
                fout.pf = pf_r;
                fout.af = aux;
                fout.zf = zf_r;
                fout.sf = sf_r;
                fout.of = ov;
            end
            OP_INC, OP_DEC: begin
                fout.pf = pf_r;
                fout.af = aux;
                fout.zf = zf_r;
                fout.sf = sf_r;
                fout.of = ov;
            end
            OP_CXD: begin
                fout.zf = (a == b);
                res     = a;
            end
            default: ;
        endcase
        we = (op == OP_ADD) || (op == OP_SUB) ||
             (op == OP_INC) || (op == OP_DEC);
    end
endmodule

// File: rtl/afu_shift.sv
// Shift and rotate datapath with flag generation for SHL, SHR, SAR, ROL and
// ROR.
// Assumes: op is a shift-group opcode; cnt is the raw count, masked here to
// 5 bits (wide = 0) or 6 bits (wide = 1) for a 64-bit datapath.
module afu_shift
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  alu_op_e           op,
    input  logic              wide,
    input  logic [DATA_W-1:0] a,
    input  logic [CNT_W-1:0]  cnt,
    input  flags_t            fin,
    output logic [DATA_W-1:0] res,
    output flags_t            fout,
    output logic              we
);
    localparam int                HALF_W    = DATA_W / 2;
    localparam logic [DATA_W-1:0] HALF_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

    logic [CNT_W-1:0]    c;
    logic [DATA_W-1:0]   mask;
    logic [DATA_W-1:0]   a_m;
    logic [DATA_W-1:0]   a_sx;
    logic [2*DATA_W-1:0] shl_t;
    logic [2*DATA_W-1:0] shr_t;
    logic [2*DATA_W-1:0] sar_t;
    logic [2*DATA_W-1:0] rol_f;
    logic [2*DATA_W-1:0] ror_f;
    logic [DATA_W-1:0]   rol_h;
    logic [DATA_W-1:0]   ror_h;
    logic [DATA_W-1:0]   sel;
    logic                cf_n;
    logic                msb_a;
    logic                msb_r;
    logic                msb2_r;
    logic                zf_r;
    logic                sf_r;
    logic                pf_r;

    // Mask the count and prepare zero- and sign-extended operands.
    always_comb begin : count_prep
        c     = wide ? cnt : {1'b0, cnt[CNT_W-2:0]};
        mask  = wide ? '1 : HALF_MASK;
        a_m   = a & mask;
        msb_a = wide ? a[DATA_W-1] : a[HALF_W-1];
        a_sx  = wide ? a : {{HALF_W{a[HALF_W-1]}}, a[HALF_W-1:0]};
    end

    // Double-width shifters; the extra half keeps the last bit shifted out.
    always_comb begin : barrel
        shl_t = {{DATA_W{1'b0}}, a_m} << c;
        shr_t = {a_m, {DATA_W{1'b0}}} >> c;
        sar_t = $signed({a_sx, {DATA_W{1'b0}}}) >>> c;
        rol_f = {a, a} << c;
        ror_f = {a, a} >> c;
        rol_h = {a[HALF_W-1:0], a[HALF_W-1:0]} << c;
        ror_h = {a[HALF_W-1:0], a[HALF_W-1:0]} >> c;
    end

    // Pick the result of the selected operation and its carry-out.
    always_comb begin : result_mux
        sel  = a_m;
        cf_n = fin.cf;
        case (op)
            OP_SHL: begin
                sel  = shl_t[DATA_W-1:0] & mask;
                cf_n = wide ? shl_t[DATA_W] : shl_t[HALF_W];
            end
            OP_SHR: begin
                sel  = shr_t[2*DATA_W-1:DATA_W];
                cf_n = shr_t[DATA_W-1];
            end
            OP_SAR: begin
                sel  = sar_t[2*DATA_W-1:DATA_W] & mask;
                cf_n = sar_t[DATA_W-1];
            end
            OP_ROL: begin
                sel  = wide ? rol_f[2*DATA_W-1:DATA_W]
                            : {{HALF_W{1'b0}}, rol_h[DATA_W-1:HALF_W]};
                cf_n = sel[0];
            end
            OP_ROR: begin
                sel  = wide ? ror_f[DATA_W-1:0]
                            : {{HALF_W{1'b0}}, ror_h[HALF_W-1:0]};
                cf_n = wide ? sel[DATA_W-1] : sel[HALF_W-1];
            end
            default: ;
        endcase
        msb_r  = wide ? sel[DATA_W-1] : sel[HALF_W-1];
        msb2_r = wide ? sel[DATA_W-2] : sel[HALF_W-2];
    end

    afu_szp #(.DATA_W(DATA_W)) u_szp (
        .res  (sel),
        .wide (wide),
        .zf   (zf_r),
        .sf   (sf_r),
        .pf   (pf_r)
    );

    // Apply the count-dependent flag rules; a zero count is a no-op.
    always_comb begin : flag_rules
        fout = fin;
        res  = a;
        we   = 1'b0;
        if (c != '0) begin
            res     = sel;
            we      = 1'b1;
            fout.cf = cf_n;
            case (op)
                OP_SHL: begin
                    fout.zf = zf_r;
                    fout.sf = sf_r;
                    fout.pf = pf_r;
                    if (c == CNT_W'(1)) fout.of = msb_r ^ cf_n;
                end
                OP_SHR: begin
                    fout.zf = zf_r;
                    fout.sf = sf_r;
                    fout.pf = pf_r;
                    if (c == CNT_W'(1)) fout.of = msb_a;
                end
                OP_SAR: begin
                    fout.zf = zf_r;
                    fout.sf = sf_r;
                    fout.pf = pf_r;
                    if (c == CNT_W'(1)) fout.of = 1'b0;
                end
                OP_ROL: begin
                    if (c == CNT_W'(1)) fout.of = msb_r ^ cf_n;
                end
                OP_ROR: begin
                    if (c == CNT_W'(1)) fout.of = msb_r ^ msb2_r;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/alu_flag_unit.sv
// Top of the ALU flag unit: routes each operation to the arithmetic or the
// shift datapath and registers the result, next flag word and write-enable
// one cycle after start_i.
// Assumes: inputs are stable around the clock edge; synchronous active-low
// reset; DATA_W is even and at least 16.
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [3:0]        op_i,
    input  logic              size_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              done_o,
    output logic [DATA_W-1:0] res_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              wr_o
);
    alu_op_e           op;
    flags_t            fl_in;
    logic [DATA_W-1:0] ar_res;
    logic [DATA_W-1:0] sh_res;
    logic [DATA_W-1:0] nx_res;
    flags_t            ar_fl;
    flags_t            sh_fl;
    flags_t            nx_fl;
    logic              ar_we;
    logic              sh_we;
    logic              nx_we;

    assign op    = alu_op_e'(op_i);
    assign fl_in = flags_t'(flags_i);

    afu_arith #(.DATA_W(DATA_W)) u_arith (
        .op   (op),
        .wide (size_i),
        .a    (a_i),
        .b    (b_i),
        .fin  (fl_in),
        .res  (ar_res),
        .fout (ar_fl),
        .we   (ar_we)
    );

    afu_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .op   (op),
        .wide (size_i),
        .a    (a_i),
        .cnt  (cnt_i),
        .fin  (fl_in),
        .res  (sh_res),
        .fout (sh_fl),
        .we   (sh_we)
    );

    // Choose the datapath by opcode group; unused opcodes pass through.
    always_comb begin : path_select
        if (op_is_shift(op_i)) begin
            nx_res = sh_res;
            nx_fl  = sh_fl;
            nx_we  = sh_we;
        end else if (op_is_arith(op_i)) begin
            nx_res = ar_res;
            nx_fl  = ar_fl;
            nx_we  = ar_we;
        end else begin
            nx_res = a_i;
            nx_fl  = fl_in;
            nx_we  = 1'b0;
        end
    end

    // Output register stage, loaded only on a strobed cycle.
    always_ff @(posedge clk_i) begin : out_reg
        if (!rst_ni) begin
            done_o  <= 1'b0;
            res_o   <= '0;
            flags_o <= '0;
            wr_o    <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                res_o   <= nx_res;
                flags_o <= nx_fl;
                wr_o    <= nx_we;
            end else begin
                wr_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/alu_flag_unit_chk.sv
// Checker for alu_flag_unit: relates each strobed operation to the
// registered outputs one cycle later. Attached to the top with bind.
// Assumes: start_i is low during reset and all inputs are known values.
module alu_flag_unit_chk
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [3:0]        op_i,
    input logic              size_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic              done_o,
    input logic [DATA_W-1:0] res_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic              wr_o
);
    logic cnt_zero;
    logic a_eq_b;

    assign cnt_zero = size_i ? (cnt_i == '0) : (cnt_i[CNT_W-2:0] == '0);
    assign a_eq_b   = (a_i == b_i);

    // R1
    done_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> done_o);

    // R1
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> (!done_o && !wr_o && $stable(res_o)));

    // R3
    cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && op_i == OP_CMP) |=> !wr_o);

    // R4
    step_keeps_cf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && (op_i == OP_INC || op_i == OP_DEC)) |=> (flags_o[0] == $past(flags_i[0])));

    // R7
    zero_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && op_is_shift(op_i) && cnt_zero)
        |=> (!wr_o && flags_o == $past(flags_i) && res_o == $past(a_i)));

    // R9
    rotate_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && (op_i == OP_ROL || op_i == OP_ROR) && !cnt_zero)
        |=> (flags_o[4:1] == $past(flags_i[4:1])));

    // R10
    cx_single_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && op_i == OP_CXS) |=> !wr_o);

    // R11
    cx_double_zf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && op_i == OP_CXD)
        |=> (flags_o[3] == $past(a_eq_b) && flags_o[5:4] == $past(flags_i[5:4])
             && flags_o[2:0] == $past(flags_i[2:0]) && !wr_o));

    // R12
    unused_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && op_i >= 4'd12) |=> (flags_o == $past(flags_i) && !wr_o));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op_i),
    .size_i  (size_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .cnt_i   (cnt_i),
    .flags_i (flags_i),
    .done_o  (done_o),
    .res_o   (res_o),
    .flags_o (flags_o),
    .wr_o    (wr_o)
);

// File: tb/alu_flag_unit_tb_top.sv
// Bench for alu_flag_unit: directed corners plus seeded random operations,
// compared with a loop-based reference model.
module alu_flag_unit_tb_top;
    localparam int W = 64;
    localparam int CW = 6;
    localparam int N_RAND = 4000;

    typedef struct packed {
        logic [W-1:0] res;
        logic [5:0]   fl;
        logic         we;
    } exp_t;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          start_i = 1'b0;
    logic [3:0]    op_i = '0;
    logic          size_i = 1'b0;
    logic [W-1:0]  a_i = '0;
    logic [W-1:0]  b_i = '0;
    logic [CW-1:0] cnt_i = '0;
    logic [5:0]    flags_i = '0;
    logic          done_o;
    logic [W-1:0]  res_o;
    logic [5:0]    flags_o;
    logic          wr_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #4ns clk_i = ~clk_i;

    alu_flag_unit #(.DATA_W(W)) dut_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .op_i    (op_i),
        .size_i  (size_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .cnt_i   (cnt_i),
        .flags_i (flags_i),
        .done_o  (done_o),
        .res_o   (res_o),
        .flags_o (flags_o),
        .wr_o    (wr_o)
    );

    function automatic logic signed [127:0] sx(input logic [W-1:0] v, input int w);
        logic signed [127:0] t;
        t = $signed({64'b0, v});
        if (v[w-1]) t = t - (128'sd1 <<< w);
        return t;
    endfunction

    function automatic logic even_ones(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return (n % 2) == 0;
    endfunction

    function automatic exp_t model(input logic [3:0] op, input logic wide,
                                   input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [CW-1:0] cnt, input logic [5:0] fi);
        exp_t e;
        int w;
        int c;
        logic [W-1:0] mask, am, bm, y, r, v;
        logic signed [127:0] s, lim;
        logic sub, cy, t;
        w    = wide ? 64 : 32;
        mask = wide ? '1 : 64'h0000_0000_FFFF_FFFF;
        am   = a & mask;
        bm   = b & mask;
        e.res = a;
        e.fl  = fi;
        e.we  = 1'b0;
        if (op <= 4'd4 || op == 4'd10) begin
            y   = (op == 4'd3 || op == 4'd4) ? 64'd1 : bm;
            sub = (op == 4'd1 || op == 4'd2 || op == 4'd4 || op == 4'd10);
            if (sub) begin
                r = (am - y) & mask;
                e.fl[0] = am < y;
                e.fl[2] = (am & 64'hF) < (y & 64'hF);
                s = sx(am, w) - sx(y, w);
            end else begin
                r = (am + y) & mask;
                e.fl[0] = ({1'b0, am} + {1'b0, y}) > {1'b0, mask};
                e.fl[2] = ((am & 64'hF) + (y & 64'hF)) > 64'd15;
                s = sx(am, w) + sx(y, w);
            end
            if (op == 4'd3 || op == 4'd4) e.fl[0] = fi[0];
            lim = 128'sd1 <<< (w - 1);
            e.fl[5] = (s >= lim) || (s < -lim);
            e.fl[4] = r[w-1];
            e.fl[3] = (r == '0);
            e.fl[1] = even_ones(r[7:0]);
            e.res = r;
            e.we  = (op == 4'd0 || op == 4'd1 || op == 4'd3 || op == 4'd4);
        end else if (op == 4'd11) begin
            e.fl[3] = (a == b);
        end else if (op >= 4'd5 && op <= 4'd9) begin
            c  = wide ? int'(cnt) : int'(cnt) % 32;
            v  = am;
            cy = fi[0];
            if (c != 0) begin
                for (int i = 0; i < c; i++) begin
                    case (op)
                        4'd5: begin cy = v[w-1]; v = (v << 1) & mask; end
                        4'd6: begin cy = v[0]; v = v >> 1; end
                        4'd7: begin cy = v[0]; v = (v >> 1) | (64'(v[w-1]) << (w - 1)); end
                        4'd8: begin t = v[w-1]; v = ((v << 1) & mask) | 64'(t); end
                        default: begin t = v[0]; v = (v >> 1) | (64'(t) << (w - 1)); end
                    endcase
                end
                if (op == 4'd8) cy = v[0];
                if (op == 4'd9) cy = v[w-1];
                e.fl[0] = cy;
                if (op <= 4'd7) begin
                    e.fl[4] = v[w-1];
                    e.fl[3] = (v == '0);
                    e.fl[1] = even_ones(v[7:0]);
                end
                if (c == 1) begin
                    case (op)
                        4'd5: e.fl[5] = v[w-1] ^ cy;
                        4'd6: e.fl[5] = am[w-1];
                        4'd7: e.fl[5] = 1'b0;
                        4'd8: e.fl[5] = v[w-1] ^ v[0];
                        default: e.fl[5] = v[w-1] ^ v[w-2];
                    endcase
                end
                e.res = v;
                e.we  = 1'b1;
            end
        end
        return e;
    endfunction

    function automatic string req_of(input logic [3:0] op, input logic wide, input logic [CW-1:0] cnt);
        int c;
        c = wide ? int'(cnt) : int'(cnt) % 32;
        case (op)
            4'd0: return "R2";
            4'd1, 4'd2: return "R3";
            4'd3, 4'd4: return "R4";
            4'd5, 4'd6, 4'd7: return (c == 0) ? "R7" : "R8";
            4'd8, 4'd9: return (c == 0) ? "R7" : "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W+6:0] act, input logic [W+6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic wide, input logic [W-1:0] a,
                          input logic [W-1:0] b, input logic [CW-1:0] cnt,
                          input logic [5:0] fl, input string tag);
        exp_t e;
        e = model(op, wide, a, b, cnt, fl);
        @(negedge clk_i);
        op_i = op; size_i = wide; a_i = a; b_i = b; cnt_i = cnt; flags_i = fl;
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        check(tag, {done_o, res_o, flags_o, wr_o}, {1'b1, e.res, e.fl, e.we});
    endtask

    initial begin : watchdog
        #(8ns * 200000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : stimulus
        logic [3:0] op;
        logic wd;
        logic [W-1:0] a, b;
        logic [CW-1:0] cn;
        void'($urandom(32'h5EED_0A1F));
        repeat (3) @(negedge clk_i);
        // R13 reset state
        check("R13", {done_o, res_o, flags_o, wr_o}, '0);
        rst_ni = 1'b1;

        // R2 carry out of bit 31 in narrow mode, upper bits zero
        run_op(4'd0, 1'b0, 64'hAAAA_0000_FFFF_FFFF, 64'h1, 6'd0, 6'h00, "R2");
        // R2 signed overflow at full width
        run_op(4'd0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 6'd0, 6'h00, "R2");
        // R5 parity and auxiliary carry: 0x0F + 0x01 = 0x10
        run_op(4'd0, 1'b1, 64'h0F, 64'h01, 6'd0, 6'h00, "R5");
        // R3 borrow and CMP no write
        run_op(4'd2, 1'b0, 64'h1, 64'h2, 6'd0, 6'h00, "R3");
        // R4 INC wraps to zero with CF kept set
        run_op(4'd3, 1'b0, 64'hFFFF_FFFF, 64'h0, 6'd0, 6'h01, "R4");
        // R4 DEC keeps CF clear
        run_op(4'd4, 1'b1, 64'h0, 64'h0, 6'd0, 6'h00, "R4");
        // R6 narrow count 33 masks to 1
        run_op(4'd5, 1'b0, 64'h8000_0000, 64'h0, 6'd33, 6'h00, "R6");
        // R6 wide count 63
        run_op(4'd6, 1'b1, 64'h8000_0000_0000_0000, 64'h0, 6'd63, 6'h00, "R6");
        // R7 narrow count 32 masks to zero
        run_op(4'd7, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0, 6'd32, 6'h2A, "R7");
        // R8 SAR by 1 of negative value, OF cleared
        run_op(4'd7, 1'b1, 64'h8000_0000_0000_0001, 64'h0, 6'd1, 6'h20, "R8");
        // R8 SHL by 4, OF unchanged
        run_op(4'd5, 1'b1, 64'hF000_0000_0000_0000, 64'h0, 6'd4, 6'h20, "R8");
        // R9 ROR by 1 narrow
        run_op(4'd9, 1'b0, 64'h1, 64'h0, 6'd1, 6'h1E, "R9");
        // R10 single compare-exchange equal operands
        run_op(4'd10, 1'b1, 64'h55, 64'h55, 6'd0, 6'h00, "R10");
        // R11 double compare-exchange, equal and unequal in upper half
        run_op(4'd11, 1'b0, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0001, 6'd0, 6'h37, "R11");
        run_op(4'd11, 1'b0, 64'hDEAD_BEEF_0000_0001, 64'h0EAD_BEEF_0000_0001, 6'd0, 6'h3F, "R11");
        // R12 unused opcode
        run_op(4'd13, 1'b1, 64'h77, 64'h1, 6'd3, 6'h15, "R12");
        // R1 done_o and wr_o drop after the strobed cycle
        @(negedge clk_i);
        check("R1", {63'b0, done_o, 6'b0, wr_o}, '0);

        for (int k = 0; k < N_RAND; k++) begin
            op = 4'($urandom % 16);
            wd = 1'($urandom);
            a  = {$urandom, $urandom};
            b  = ($urandom % 4 == 0) ? a : {$urandom, $urandom};
            case ($urandom % 4)
                0: cn = 6'($urandom % 3);
                1: cn = 6'(31 + $urandom % 3);
                2: cn = 6'(62 + $urandom % 2);
                default: cn = 6'($urandom);
            endcase
            run_op(op, wd, a, b, cn, 6'($urandom), req_of(op, wd, cn));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule